// File: doc/BRIEF.md
# Tape Controller Command and Status Register Front End

This block is the register-facing part of a block-addressed magnetic tape controller on a 16-bit peripheral bus. It holds three word registers: a command register (function code, unit select, interrupt enable, GO, DONE, summary ERROR), a status register made of individual error flops, and a data register. The block decodes bus reads and writes with byte-lane enables. It starts and stops tape motion on a per-unit run vector, tracks operation completion in DONE, and drives a level interrupt request.

Any write to the command register starts the selected unit unless the function written is a stop. A GO bit is not needed to start motion. The error flops are set by single-cycle pulses from the transport side. They are cleared either by a GO write or by writing 0 to the summary ERROR bit. A completion pulse from the transport sets DONE, but only when DONE is not already set. A small two-state machine tracks whether an operation is in flight. ST_IDLE goes to ST_RUN on an accepted motion command. ST_RUN goes back to ST_IDLE on a completion pulse, on a stop command, or on an illegal-operation error.

Top module: `tape_regs_top`

## Requirements
- R1: After reset, DONE reads 1, every error flop and the data register read 0, the function, unit and interrupt-enable fields read 0, no unit runs, busy is low and irq is low.
- R2: The command register layout is GO bit 0, function bits [3:1], interrupt enable bit 6, DONE bit 7, unit bits [10:8] and ERROR bit 15. Function codes are 0 stop-all, 1 stop-selected, 2 read-mark, 3 read-all, 4 read-data, 5 write-timing-mark, 6 write-data and 7 write-all. Any command write whose function is 2 to 7 sets the run bit of the selected unit and raises busy (ST_IDLE to ST_RUN), whether or not GO is written as 1.
- R3: A stop-all command write clears every run bit. An accepted stop-selected write clears only the selected unit's run bit. Both leave busy low.
- R4: A command write whose low lane carries GO=1 clears DONE and all error flops.
- R5: A command write with the high lane enabled and bit 15 equal to 0 clears all error flops. Bit 15 written as 1, or the high lane disabled, leaves them as they were.
- R6: The status register holds its error flops at bits [15:9]: 9 data late, 10 block missing, 11 select error, 12 illegal operation, 13 mark-track error, 14 parity, 15 end zone. Each flop is set by bit i of err_pulse for bit 9+i. Command bit 15 always reads the OR of these flops.
- R7: While the select-error flop is set and the same write does not clear it, every command function except stop-all leaves the run vector and busy unchanged. Stop-all still takes effect.
- R8: An illegal-operation pulse clears the run bit of the selected unit and drops busy.
- R9: A data-register write stores the enabled byte lanes. It clears DONE when the current function is read-all, write-all or write-timing-mark, and has no effect on DONE otherwise.
- R10: A data-register read strobe clears DONE only when the current function is read-all.
- R11: A completion pulse sets DONE when DONE is clear and ends ST_RUN. When DONE is already set, the pulse leaves DONE and irq unchanged.
- R12: irq is high exactly while DONE and interrupt enable are both set.
- R13: In the same cycle, a GO write's clear of DONE takes priority over a completion pulse, and an error pulse takes priority over an error clear.
- R14: Writes to the status register and to the DONE bit position change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (for read side effects) |
| byte_en | input | 2 | Byte lane enables, bit 0 low byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| err_pulse | input | 7 | Single-cycle error set pulses |
| op_done | input | 1 | Operation-complete pulse |
| unit_run | output | 8 | Per-unit motion enable |
| busy | output | 1 | Operation in flight (ST_RUN) |
| cur_func | output | 3 | Current function code |
| cur_unit | output | 3 | Currently selected unit |
| irq | output | 1 | Interrupt request level |

## Verification
Two collisions can land in one cycle. A GO command write can arrive together with the transport's completion pulse, and an error-clearing command write can arrive together with an error pulse. Directed cases drive both inputs on the same edge. The bench then expects DONE to stay clear with the new operation running, and the pulsed error flop to remain set. The random phase also mixes error and completion pulses with bus traffic, and scores every cycle against a bench model that applies these priorities.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;

    localparam int WORD_W   = 16;
    localparam int ERR_BASE = 9;
    localparam int SEL_IDX  = 2;
    localparam int ILO_IDX  = 3;

    typedef enum logic [2:0] {
        FN_STOP_ALL = 3'd0,
        FN_STOP_SEL = 3'd1,
        FN_RD_MARK  = 3'd2,
        FN_RD_ALL   = 3'd3,
        FN_RD_DATA  = 3'd4,
        FN_WR_TMARK = 3'd5,
        FN_WR_DATA  = 3'd6,
        FN_WR_ALL   = 3'd7
    } tfunc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xstate_e;

endpackage

// File: rtl/tape_err_bank.sv
module tape_err_bank #(
    parameter int NERR = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NERR-1:0] set_pulse,
    output logic [NERR-1:0] err_q,
    output logic            err_any
);

    for (genvar i = 0; i < NERR; i++) begin : g_flop
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_q[i] <= 1'b0;
            else if (set_pulse[i])
                err_q[i] <= 1'b1;
            else if (clr)
                err_q[i] <= 1'b0;
        end
    end

    assign err_any = |err_q;

endmodule

// File: rtl/tape_motion_fsm.sv
module tape_motion_fsm
    import tape_regs_pkg::*;
#(
    parameter int UNIT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  tfunc_e                 func_next,
    input  logic [UNIT_W-1:0]      unit_next,
    input  logic                   sel_blk,
    input  logic                   ilo_pulse,
    input  logic                   op_done,
    output logic [(1<<UNIT_W)-1:0] unit_run,
    output logic                   busy
);

    localparam int NUNITS = 1 << UNIT_W;

    xstate_e           state_q, state_n;
    logic [NUNITS-1:0] run_q, run_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        if (cmd_wr) begin
            if (func_next == FN_STOP_ALL) begin
                run_n   = '0;
                state_n = ST_IDLE;
            end else if (!sel_blk) begin
                if (func_next == FN_STOP_SEL) begin
                    run_n[unit_next] = 1'b0;
                    state_n          = ST_IDLE;
                end else begin
                    run_n[unit_next] = 1'b1;
                    state_n          = ST_RUN;
                end
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_RUN:  if (op_done) state_n = ST_IDLE;
                default: state_n = ST_IDLE;
            endcase
        end
        if (ilo_pulse) begin
            run_n[unit_next] = 1'b0;
            state_n          = ST_IDLE;
        end
    end

    always_comb begin
        busy     = (state_q == ST_RUN);
        unit_run = run_q;
    end

endmodule

// File: rtl/tape_regs_top.sv
module tape_regs_top
    import tape_regs_pkg::*;
#(
    parameter int UNIT_W = 3,
    parameter int NERR   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             reg_sel,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             byte_en,
    input  logic [WORD_W-1:0]      wdata,
    output logic [WORD_W-1:0]      rdata,
    input  logic [NERR-1:0]        err_pulse,
    input  logic                   op_done,
    output logic [(1<<UNIT_W)-1:0] unit_run,
    output logic                   busy,
    output logic [2:0]             cur_func,
    output logic [UNIT_W-1:0]      cur_unit,
    output logic                   irq
);

    localparam int PAD_W = 7 - UNIT_W;

    tfunc_e              func_q, func_next;
    logic [UNIT_W-1:0]   unit_q, unit_next;
    logic                ie_q, done_q, done_n;
    logic [WORD_W-1:0]   data_q;
    logic                cmd_wr, go_wr, err_clr, sel_blk, ilo_pulse;
    logic                data_wr, data_rd, err_any;
    logic [NERR-1:0]     err_q;
    logic [WORD_W-1:0]   cmd_view, stat_view;
    logic                unused_bits;

    assign unused_bits = ^{wdata[14:11], wdata[7], wdata[5:4]};

    assign cmd_wr    = wr_en && (reg_sel == 2'd0) && (|byte_en);
    assign go_wr     = cmd_wr && byte_en[0] && wdata[0];
    assign err_clr   = go_wr || (cmd_wr && byte_en[1] && !wdata[15]);
    assign func_next = (cmd_wr && byte_en[0]) ? tfunc_e'(wdata[3:1]) : func_q;
    assign unit_next = (cmd_wr && byte_en[1]) ? wdata[8 +: UNIT_W] : unit_q;
    assign sel_blk   = err_q[SEL_IDX] && !err_clr;
    assign ilo_pulse = err_pulse[ILO_IDX];
    assign data_wr   = wr_en && (reg_sel == 2'd2);
    assign data_rd   = rd_en && (reg_sel == 2'd2);

    tape_err_bank #(.NERR(NERR)) err_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (err_clr),
        .set_pulse (err_pulse),
        .err_q     (err_q),
        .err_any   (err_any)
    );

    tape_motion_fsm #(.UNIT_W(UNIT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .func_next (func_next),
        .unit_next (unit_next),
        .sel_blk   (sel_blk),
        .ilo_pulse (ilo_pulse),
        .op_done   (op_done),
        .unit_run  (unit_run),
        .busy      (busy)
    );

    always_comb begin
        done_n = done_q;
        if (op_done && !done_q)
            done_n = 1'b1;
        if (data_wr && (func_q == FN_RD_ALL || func_q == FN_WR_ALL ||
                        func_q == FN_WR_TMARK))
            done_n = 1'b0;
        if (data_rd && func_q == FN_RD_ALL)
            done_n = 1'b0;
        if (go_wr)
            done_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= FN_STOP_ALL;
            unit_q <= '0;
            ie_q   <= 1'b0;
            done_q <= 1'b1;
            data_q <= '0;
        end else begin
            func_q <= func_next;
            unit_q <= unit_next;
            done_q <= done_n;
            if (cmd_wr && byte_en[0])
                ie_q <= wdata[6];
            if (data_wr && byte_en[0])
                data_q[7:0] <= wdata[7:0];
            if (data_wr && byte_en[1])
                data_q[15:8] <= wdata[15:8];
        end
    end

    assign cmd_view  = {err_any, {PAD_W{1'b0}}, unit_q, done_q, ie_q,
                        2'b00, func_q, 1'b0};
    assign stat_view = {err_q, {ERR_BASE{1'b0}}};

    always_comb begin
        unique case (reg_sel)
            2'd0:    rdata = cmd_view;
            2'd1:    rdata = stat_view;
            2'd2:    rdata = data_q;
            default: rdata = '0;
        endcase
    end

    assign irq      = done_q && ie_q;
    assign cur_func = func_q;
    assign cur_unit = unit_q;

endmodule

// File: rtl/tape_regs_chk.sv
module tape_regs_chk #(
    parameter int UNIT_W = 3,
    parameter int NERR   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_wr,
    input logic                   go_wr,
    input logic                   err_clr,
    input logic [2:0]             func_next,
    input logic                   sel_flop,
    input logic                   ilo_pulse,
    input logic [NERR-1:0]        err_pulse,
    input logic [NERR-1:0]        err_q,
    input logic [(1<<UNIT_W)-1:0] unit_run,
    input logic [UNIT_W-1:0]      cur_unit,
    input logic [15:0]            cmd_view,
    input logic                   irq
);

    AST_GO_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && err_pulse == '0) |=> (err_q == '0)); // R4

    AST_STOP_ALL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && func_next == 3'd0) |=> (unit_run == '0)); // R3

    AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && func_next != 3'd0 && sel_flop && !err_clr && !ilo_pulse)
        |=> $stable(unit_run)); // R7

    AST_ILO_STOPS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ilo_pulse |=> !unit_run[cur_unit]); // R8

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmd_view[6] && cmd_view[7])); // R12

    always_comb begin
        if (rst_n)
            AST_ERR_SUMMARY: assert (cmd_view[15] == (|err_q)); // R6
    end

endmodule

bind tape_regs_top tape_regs_chk #(.UNIT_W(UNIT_W), .NERR(NERR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .go_wr     (go_wr),
    .err_clr   (err_clr),
    .func_next (func_next),
    .sel_flop  (err_q[2]),
    .ilo_pulse (ilo_pulse),
    .err_pulse (err_pulse),
    .err_q     (err_q),
    .unit_run  (unit_run),
    .cur_unit  (cur_unit),
    .cmd_view  (cmd_view),
    .irq       (irq)
);

// File: tb/tape_regs_top_tb_top.sv
`timescale 1ns/1ps
module tape_regs_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  err_pulse = '0;
    logic        op_done = 1'b0;
    logic [7:0]  unit_run;
    logic        busy, irq;
    logic [2:0]  cur_func, cur_unit;

    int checks = 0, errors = 0;

    // model state
    logic [2:0]  m_func, m_unit;
    logic        m_ie, m_done, m_busy;
    logic [6:0]  m_err;
    logic [7:0]  m_run;
    logic [15:0] m_data;

    always #4 clk = ~clk;

    tape_regs_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .err_pulse(err_pulse),
        .op_done(op_done), .unit_run(unit_run), .busy(busy), .cur_func(cur_func),
        .cur_unit(cur_unit), .irq(irq)
    );

    function automatic logic [15:0] exp_cmd();
        return {|m_err, 4'b0, m_unit, m_done, m_ie, 2'b00, m_func, 1'b0};
    endfunction

    function automatic logic [15:0] exp_stat();
        return {m_err, 9'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_func = 0; m_unit = 0; m_ie = 0; m_done = 1; m_busy = 0;
        m_err = 0; m_run = 0; m_data = 0;
    endtask

    // one bus/transport cycle; called and returns at a falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [1:0] sel,
                       input logic [1:0] be, input logic [15:0] wd,
                       input logic [6:0] ep, input logic dn);
        logic cw, go, clr, blk, nie, dne;
        logic [2:0] nf, nu;
        logic [7:0] run;
        logic bz;
        wr_en = wr; rd_en = rd; reg_sel = sel; byte_en = be; wdata = wd;
        err_pulse = ep; op_done = dn;
        cw  = wr && sel == 2'd0 && be != 2'b00;
        go  = cw && be[0] && wd[0];
        clr = go || (cw && be[1] && !wd[15]);
        nf  = (cw && be[0]) ? wd[3:1] : m_func;
        nu  = (cw && be[1]) ? wd[10:8] : m_unit;
        nie = (cw && be[0]) ? wd[6] : m_ie;
        blk = m_err[2] && !clr;
        run = m_run; bz = m_busy;
        if (cw) begin
            if (nf == 3'd0) begin run = '0; bz = 0; end
            else if (!blk) begin
                if (nf == 3'd1) begin run[nu] = 0; bz = 0; end
                else begin run[nu] = 1; bz = 1; end
            end
        end else if (bz && dn) bz = 0;
        if (ep[3]) begin run[nu] = 0; bz = 0; end
        dne = m_done;
        if (dn && !dne) dne = 1;
        if (wr && sel == 2'd2 && (m_func == 3 || m_func == 5 || m_func == 7)) dne = 0;
        if (rd && sel == 2'd2 && m_func == 3) dne = 0;
        if (go) dne = 0;
        m_err = (clr ? 7'd0 : m_err) | ep;
        if (wr && sel == 2'd2 && be[0]) m_data[7:0] = wd[7:0];
        if (wr && sel == 2'd2 && be[1]) m_data[15:8] = wd[15:8];
        m_func = nf; m_unit = nu; m_ie = nie; m_done = dne; m_run = run; m_busy = bz;
        @(negedge clk);
        wr_en = 0; rd_en = 0; byte_en = 0; err_pulse = 0; op_done = 0;
    endtask

    task automatic check_all(input string req);
        reg_sel = 2'd0; #1; chk({req, " cmd"}, rdata, exp_cmd());
        reg_sel = 2'd1; #1; chk({req, " stat"}, rdata, exp_stat());
        reg_sel = 2'd2; #1; chk({req, " data"}, rdata, m_data);
        chk({req, " run"}, unit_run, m_run);
        chk({req, " busy"}, busy, m_busy);
        chk({req, " irq R12"}, irq, m_done && m_ie);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: start without GO, function read-data unit 5
        cyc(1, 0, 0, 2'b11, 16'h8508, 0, 0);
        check_all("R2 start no GO");
        chk("R2 run bit", unit_run[5], 1'b1);
        // R11: completion sets DONE? DONE still 1 from reset; clear with GO first
        cyc(1, 0, 0, 2'b11, 16'h8549, 0, 0);   // GO, ie, read-data unit 5
        check_all("R4 GO clears DONE");
        cyc(0, 0, 0, 0, 0, 0, 1);
        check_all("R11 completion sets DONE");
        chk("R12 irq up", irq, 1'b1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        check_all("R11 second completion no change");
        // R5: error then clear via 0 in bit 15 vs 1
        cyc(0, 0, 0, 0, 0, 7'b0100001, 0);
        check_all("R6 errors set");
        cyc(1, 0, 0, 2'b10, 16'h8500, 0, 0);
        check_all("R5 write 1 keeps errors");
        cyc(1, 0, 0, 2'b01, 16'h0048, 0, 0);
        check_all("R5 high lane off keeps errors");
        cyc(1, 0, 0, 2'b10, 16'h0500, 0, 0);
        check_all("R5 write 0 clears errors");
        // R7: select error rejects, stop-all still works
        cyc(1, 0, 0, 2'b11, 16'h820C, 0, 0);  // write-data unit 2
        cyc(0, 0, 0, 0, 0, 7'b0000100, 0);
        cyc(1, 0, 0, 2'b11, 16'h830E, 0, 0);  // write-all unit 3 rejected
        check_all("R7 rejected");
        cyc(1, 0, 0, 2'b11, 16'h8302, 0, 0);  // stop-selected rejected
        check_all("R7 stop-sel rejected");
        cyc(1, 0, 0, 2'b11, 16'h8300, 0, 0);  // stop-all
        check_all("R3 R7 stop-all with select error");
        // R8 illegal op stops selected unit
        cyc(1, 0, 0, 2'b11, 16'h0408, 0, 0);
        cyc(0, 0, 0, 0, 0, 7'b0001000, 0);
        check_all("R8 illegal op stop");
        // R9/R10 data accesses
        cyc(1, 0, 0, 2'b11, 16'h0007, 0, 0);  // GO read-all
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 1, 2, 0, 0, 0, 0);
        check_all("R10 read clears DONE in read-all");
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 2, 2'b01, 16'hABCD, 0, 0);
        check_all("R9 write clears DONE in read-all, low lane");
        cyc(1, 0, 0, 2'b01, 16'h0008, 0, 0);  // read-data
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 2, 2'b10, 16'h1234, 0, 0);
        cyc(0, 1, 2, 0, 0, 0, 0);
        check_all("R9 R10 read-data leaves DONE");
        // R13 collisions
        cyc(1, 0, 0, 2'b01, 16'h000D, 0, 1);  // GO + completion same cycle
        check_all("R13 GO beats completion");
        cyc(1, 0, 0, 2'b10, 16'h0000, 7'b0010000, 0);
        check_all("R13 error pulse beats clear");
        // R14 status write and DONE bit ignored
        cyc(1, 0, 1, 2'b11, 16'h0000, 0, 0);
        check_all("R14 status write ignored");
        cyc(1, 0, 0, 2'b01, 16'h0080, 0, 0);
        check_all("R14 DONE bit ignored");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [15:0] wd;
            logic [1:0] be;
            logic [6:0] ep;
            op = $urandom % 6;
            wd = 16'($urandom);
            be = 2'($urandom % 3 + 1);
            ep = ($urandom % 4 == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
            if ($urandom % 10 < 7) wd[15] = 1'b1;
            if ($urandom % 10 < 7) wd[0] = 1'b0;
            case (op)
                0, 1: cyc(1, 0, 0, be, wd, ep, $urandom % 4 == 0);
                2:    cyc(1, 0, 2, be, wd, ep, $urandom % 4 == 0);
                3:    cyc(0, 1, 2, 0, 0, ep, $urandom % 4 == 0);
                4:    cyc(0, 0, 0, 0, 0, ep, 1);
                default: cyc(1, 0, 1, be, wd, ep, 0);
            endcase
            check_all("R2 R6 R13 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule